// File: doc/BRIEF.md
# FIFO-Buffered Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port. Software writes data words into a sixteen-entry transmit queue. A sequencer takes words from the head of the queue and sends each one on a serial data line, one bit per serial clock period. The line changes only after a falling serial-clock edge, so a receiver can sample it on the rising edge. A programmable watermark drives a data-request flag that tells software when the queue has room to be refilled.

Word framing comes from a start strobe. The strobe can be an input from an external master, or the block can generate it itself. When the block generates it, there are two pacings. In interval pacing, a fixed number of idle serial clock periods separates successive words. In continuous pacing, each word follows the previous word's last bit with no gap. The serial clock and the external strobe come from outside and are resynchronised into the system clock domain. Every sequencing decision is made on detected serial-clock edges.

Top module: `fifo_serial_tx`

## Requirements
- R1: `tx_req` is 1 whenever the number of queued words is less than or equal to `cfg_watermark`. It goes to 0 as soon as writes raise the count above that value.
- R2: The queue holds 16 words. `fifo_full` is 1 exactly when 16 words are held, and `fifo_empty` is 1 exactly when none are held.
- R3: A write while `fifo_full` is 1 is discarded and does not reach the serial line. It sets `overflow`, which stays 1 until reset.
- R4: With `cfg_lsb_first` = 0, each 8-bit word is sent most significant bit first.
- R5: With `cfg_lsb_first` = 1, each 8-bit word is sent least significant bit first.
- R6: With `cfg_strobe_int` = 0, a word starts only after `strb_in` was seen high at a rising serial-clock edge. Its first bit appears after the next falling edge. A strobe seen while the queue is empty is discarded, and `strb_out` stays 0.
- R7: With `cfg_strobe_int` = 1, `strb_out` is 1 for exactly one serial clock period, the period carrying the first bit of each word.
- R8: With `cfg_strobe_int` = 1 and `cfg_continuous` = 0, successive words are separated by GAP_CLKS idle periods (default 2). During those periods `txd` holds the last bit sent.
- R9: With `cfg_strobe_int` = 1 and `cfg_continuous` = 1, a queued word's first bit directly follows the previous word's last bit.
- R10: `txd` changes only in response to a falling serial-clock edge, and never while `sclk` is high.
- R11: While the queue is empty, no transfer starts and `txd` keeps its last value.
- R12: After reset, `txd` = 0, `strb_out` = 0, `fifo_empty` = 1, `fifo_full` = 0 and `overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push one word into the queue |
| wr_data | input | 8 | Word to push |
| cfg_watermark | input | 4 | Request threshold for `tx_req` |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_strobe_int | input | 1 | 0: external strobe input, 1: internally generated strobe |
| cfg_continuous | input | 1 | Internal strobe pacing: 0 interval, 1 back to back |
| sclk | input | 1 | Serial clock |
| strb_in | input | 1 | External start strobe |
| strb_out | output | 1 | Generated start strobe |
| txd | output | 1 | Serial data |
| tx_req | output | 1 | Data request, queue at or below watermark |
| fifo_full | output | 1 | Queue holds 16 words |
| fifo_empty | output | 1 | Queue holds no word |
| overflow | output | 1 | Sticky flag for a write dropped while full |

## Verification
The bench fills the queue past its capacity and then drains it. A design that did not drop the seventeenth write would send it as a seventeenth word or corrupt the head. The bench sends an external strobe while the queue is empty and then pushes a word. A design that kept the stale strobe would start sending without a fresh one. Interval and continuous pacing are told apart by the spacing between generated strobes, so an off-by-one gap counter shows up as a spacing of 9 or 11 instead of 10. A monitor also flags any change of `txd` while `sclk` is high.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef struct packed {
      logic lsb_first;
      logic strobe_int;
      logic continuous;
   } sertx_mode_t;

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
   parameter int N      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_in,
   output logic [N-1:0] d_out
);

   if (N < 1) begin : g_bad_n
      $error("sertx_sync: N must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_chain
      logic [N-1:0] stg [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= d_in;
            else             stg[s] <= stg[(s > 0) ? s-1 : 0];
         end
      end
      assign d_out = stg[STAGES-1];
   end

endmodule

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_data,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             overflow
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("sertx_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(1);
         if (push_ok && !pop_ok)      level <= level + LVL_W'(1);
         else if (pop_ok && !push_ok) level <= level - LVL_W'(1);
         if (push && full) overflow <= 1'b1;
      end
   end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
   import sertx_pkg::*;
#(
   parameter int W   = 8,
   parameter int GAP = 2,
   localparam int CNT_W = (W > 1) ? $clog2(W) : 1,
   localparam int GAP_W = $clog2(GAP + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  sertx_mode_t  mode,
   input  logic         sclk_rise,
   input  logic         sclk_fall,
   input  logic         strb_lvl,
   input  logic         fifo_empty,
   input  logic [W-1:0] head,
   output logic         pop,
   output logic         txd,
   output logic         strb_out,
   output logic         busy
);

   if (W < 2) begin : g_bad_w
      $error("sertx_seq: W must be at least 2");
   end
   if (GAP < 1) begin : g_bad_gap
      $error("sertx_seq: GAP must be at least 1");
   end

   logic [W-1:0]     shreg;
   logic [CNT_W-1:0] bit_cnt;
   logic [GAP_W-1:0] gap_cnt;
   logic             strb_seen, lsb_q;
   logic             last_bit, trig_ok, start;

   assign last_bit = busy && (bit_cnt == CNT_W'(W - 1));
   always_comb begin
      if (mode.strobe_int)
         trig_ok = mode.continuous ? 1'b1 : (!busy && gap_cnt == '0);
      else
         trig_ok = strb_seen;
   end
   assign start = sclk_fall && !fifo_empty && trig_ok && (!busy || last_bit);
   assign pop   = start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strb_seen <= 1'b0;
      end else if (sclk_rise) begin
         strb_seen <= strb_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         bit_cnt  <= '0;
         gap_cnt  <= '0;
         busy     <= 1'b0;
         lsb_q    <= 1'b0;
         txd      <= 1'b0;
         strb_out <= 1'b0;
      end else if (sclk_fall) begin
         strb_out <= 1'b0;
         if (start) begin
            busy     <= 1'b1;
            bit_cnt  <= '0;
            lsb_q    <= mode.lsb_first;
            strb_out <= mode.strobe_int;
            txd      <= mode.lsb_first ? head[0] : head[W-1];
            shreg    <= mode.lsb_first ? (head >> 1) : (head << 1);
         end else if (busy && !last_bit) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
            txd     <= lsb_q ? shreg[0] : shreg[W-1];
            shreg   <= lsb_q ? (shreg >> 1) : (shreg << 1);
         end else if (last_bit) begin
            busy    <= 1'b0;
            gap_cnt <= (mode.strobe_int && !mode.continuous) ? GAP_W'(GAP - 1) : '0;
         end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - GAP_W'(1);
         end
      end
   end

endmodule

// File: rtl/fifo_serial_tx.sv
module fifo_serial_tx
   import sertx_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int DEPTH       = 16,
   parameter int WM_W        = 4,
   parameter int GAP_CLKS    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WM_W-1:0]   cfg_watermark,
   input  logic              cfg_lsb_first,
   input  logic              cfg_strobe_int,
   input  logic              cfg_continuous,
   input  logic              sclk,
   input  logic              strb_in,
   output logic              strb_out,
   output logic              txd,
   output logic              tx_req,
   output logic              fifo_full,
   output logic              fifo_empty,
   output logic              overflow
);

   if (WM_W < 1 || WM_W > 16) begin : g_bad_wm
      $error("fifo_serial_tx: WM_W out of range");
   end

   logic [1:0]        sync_v;
   logic              sclk_d, sclk_rise, sclk_fall;
   logic              seq_busy, pop;
   logic [WORD_W-1:0] head;
   logic [LVL_W-1:0]  level;
   sertx_mode_t       mode;

   sertx_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({strb_in, sclk}),
      .d_out (sync_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sync_v[0];
   end
   assign sclk_rise = sync_v[0] && !sclk_d;
   assign sclk_fall = !sync_v[0] && sclk_d;

   assign mode = '{lsb_first: cfg_lsb_first, strobe_int: cfg_strobe_int,
                   continuous: cfg_continuous};

   sertx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (pop),
      .head      (head),
      .level     (level),
      .full      (fifo_full),
      .empty     (fifo_empty),
      .overflow  (overflow)
   );

   sertx_seq #(.W(WORD_W), .GAP(GAP_CLKS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .strb_lvl   (sync_v[1]),
      .fifo_empty (fifo_empty),
      .head       (head),
      .pop        (pop),
      .txd        (txd),
      .strb_out   (strb_out),
      .busy       (seq_busy)
   );

   assign tx_req = (32'(level) <= 32'(cfg_watermark));

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic fifo_full,
   input logic fifo_empty,
   input logic overflow,
   input logic txd,
   input logic strb_out,
   input logic cfg_strobe_int,
   input logic sclk_fall,
   input logic busy
);

   assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty))
      else $error("full and empty together");

   assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow)
      else $error("overflow flag cleared");

   assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && fifo_full) |=> overflow)
      else $error("write while full did not set overflow");

   assert_no_strobe_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_strobe_int |-> !strb_out)
      else $error("strobe driven in external mode");

   assert_txd_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(txd))
      else $error("txd changed without a falling serial edge");

   assert_no_start_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !busy) |=> !$rose(strb_out))
      else $error("transfer started from an empty queue");

endmodule

bind fifo_serial_tx sertx_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .fifo_full      (fifo_full),
   .fifo_empty     (fifo_empty),
   .overflow       (overflow),
   .txd            (txd),
   .strb_out       (strb_out),
   .cfg_strobe_int (cfg_strobe_int),
   .sclk_fall      (sclk_fall),
   .busy           (seq_busy)
);

// File: tb/fifo_serial_tx_tb.sv
`timescale 1ns/1ps
module fifo_serial_tx_tb;

   logic       clk = 1'b0, rst_n = 1'b0, sclk = 1'b0;
   logic       wr_en = 1'b0, strb_in = 1'b0;
   logic [7:0] wr_data = '0;
   logic [3:0] cfg_watermark = 4'd3;
   logic       cfg_lsb_first = 1'b0, cfg_strobe_int = 1'b0, cfg_continuous = 1'b0;
   logic       strb_out, txd, tx_req, fifo_full, fifo_empty, overflow;

   int checks = 0, fails = 0, rec_n = 0, hi_changes = 0;
   logic rec_txd  [0:2047];
   logic rec_strb [0:2047];
   int   sidx [0:31];
   int   scount;

   localparam int GAP = 2;
   // {lsb_first, continuous, word0, word1}
   localparam logic [17:0] VEC [4] = '{
      {1'b0, 1'b0, 8'hA5, 8'h3C},
      {1'b1, 1'b0, 8'hA5, 8'h3C},
      {1'b0, 1'b1, 8'h81, 8'h7E},
      {1'b1, 1'b1, 8'hC4, 8'h1F}
   };

   fifo_serial_tx u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .cfg_watermark(cfg_watermark), .cfg_lsb_first(cfg_lsb_first),
      .cfg_strobe_int(cfg_strobe_int), .cfg_continuous(cfg_continuous),
      .sclk(sclk), .strb_in(strb_in), .strb_out(strb_out), .txd(txd),
      .tx_req(tx_req), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
      .overflow(overflow)
   );

   always #5 clk = ~clk;
   initial begin
      #3;
      forever #80 sclk = ~sclk;
   end

   always @(posedge sclk) begin
      if (rec_n < 2048) begin
         rec_txd[rec_n]  <= txd;
         rec_strb[rec_n] <= strb_out;
         rec_n <= rec_n + 1;
      end
   end

   always @(txd) if (sclk === 1'b1 && rst_n === 1'b1) hi_changes++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wait_sclk(input int n);
      repeat (n) @(posedge sclk);
      #2;
   endtask

   task automatic find_strobes(input int from);
      scount = 0;
      for (int i = from; i < rec_n; i++)
         if (rec_strb[i] === 1'b1 && scount < 32) begin
            sidx[scount] = i;
            scount++;
         end
   endtask

   function automatic logic [7:0] get_word(input int idx, input logic lsb);
      logic [7:0] w;
      for (int b = 0; b < 8; b++)
         if (lsb) w[b] = rec_txd[idx+b];
         else     w[7-b] = rec_txd[idx+b];
      return w;
   endfunction

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int base, k, held_ok;
      logic [17:0] v;
      logic lastb;
      repeat (5) @(negedge clk);
      // R12 reset state
      chk("R12 txd", txd, 0);
      chk("R12 strb_out", strb_out, 0);
      chk("R12 empty", fifo_empty, 1);
      chk("R12 full", fifo_full, 0);
      chk("R12 overflow", overflow, 0);
      rst_n = 1'b1;
      wait_sclk(2);

      // vector table, internal strobe: R4 R5 R7 R8 R9 R11
      cfg_strobe_int = 1'b1;
      for (int t = 0; t < 4; t++) begin
         v = VEC[t];
         @(negedge clk);
         cfg_lsb_first = v[17]; cfg_continuous = v[16];
         base = rec_n;
         push(v[15:8]);
         push(v[7:0]);
         wait_sclk(30);
         find_strobes(base);
         chk("R7 strobe count", scount, 2);
         if (scount == 2) begin
            chk(v[17] ? "R5 word0" : "R4 word0", get_word(sidx[0], v[17]), v[15:8]);
            chk(v[17] ? "R5 word1" : "R4 word1", get_word(sidx[1], v[17]), v[7:0]);
            if (v[16]) chk("R9 spacing", sidx[1] - sidx[0], 8);
            else begin
               chk("R8 spacing", sidx[1] - sidx[0], 8 + GAP);
               lastb = v[17] ? v[15] : v[8];
               for (int g = 0; g < GAP; g++)
                  chk("R8 gap hold", rec_txd[sidx[0]+8+g], lastb);
            end
            lastb = v[17] ? v[7] : v[0];
            held_ok = 1;
            for (int i = sidx[1] + 8; i < rec_n; i++)
               if (rec_txd[i] !== lastb) held_ok = 0;
            chk("R11 idle hold", held_ok, 1);
         end
      end

      // watermark and capacity, external mode without strobes: R1 R2 R3
      @(negedge clk);
      cfg_strobe_int = 1'b0; cfg_lsb_first = 1'b0; cfg_continuous = 1'b0;
      cfg_watermark = 4'd3;
      @(negedge clk);
      chk("R1 req at 0", tx_req, 1);
      for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
      chk("R1 req at 3", tx_req, 1);
      chk("R2 not empty", fifo_empty, 0);
      push(8'h13);
      chk("R1 req at 4", tx_req, 0);
      for (int i = 4; i < 15; i++) push(8'h10 + 8'(i));
      chk("R2 not full at 15", fifo_full, 0);
      push(8'h1F);
      chk("R2 full at 16", fifo_full, 1);
      chk("R3 no overflow yet", overflow, 0);
      push(8'hEE);
      chk("R3 overflow set", overflow, 1);
      chk("R2 still full", fifo_full, 1);

      // drain, internal continuous: R3 R9
      @(negedge clk);
      cfg_strobe_int = 1'b1; cfg_continuous = 1'b1;
      base = rec_n;
      wait_sclk(140);
      find_strobes(base);
      chk("R3 sixteen words only", scount, 16);
      for (int i = 0; i < 16 && i < scount; i++)
         chk("R3 drained word", get_word(sidx[i], 1'b0), 8'h10 + 8'(i));
      if (scount == 16) chk("R9 drain spacing", sidx[15] - sidx[0], 15 * 8);
      chk("R2 empty after drain", fifo_empty, 1);
      chk("R1 req after drain", tx_req, 1);
      chk("R3 overflow sticky", overflow, 1);

      // external strobe: R6 R11
      @(negedge clk);
      cfg_strobe_int = 1'b0; cfg_continuous = 1'b0;
      @(negedge sclk); #1 strb_in = 1'b1;
      @(negedge sclk); #1 strb_in = 1'b0;
      wait_sclk(1);
      push(8'h96);
      base = rec_n;
      wait_sclk(12);
      held_ok = 1;
      for (int i = base; i < rec_n; i++) if (rec_txd[i] !== 1'b1) held_ok = 0;
      chk("R11 hold without fresh strobe", held_ok, 1);
      chk("R6 stale strobe discarded", fifo_empty, 0);
      @(negedge sclk); #1 strb_in = 1'b1; k = rec_n;
      @(negedge sclk); #1 strb_in = 1'b0;
      wait_sclk(12);
      chk("R6 word after strobe", get_word(k + 1, 1'b0), 8'h96);
      chk("R6 consumed", fifo_empty, 1);
      find_strobes(base);
      chk("R6 no strb_out", scount, 0);

      chk("R10 txd changes while sclk high", hi_changes, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule